// File: doc/BRIEF.md
# Serial Shift Register with Parallel Storage Loop

The block holds a parallel-out holding register and a serial shifter, both parameterized to 16 bits by default. The two registers are wired in a loop, so each can be copied into the other.

Serial traffic uses one shared bidirectional line, which is split here into an input bit, an output bit and an output-enable. A mode input selects the direction of that line. In write mode, the shifter takes the input bit at its low end. In read mode, the shifter drives its top bit out and feeds that same bit back into its low end, so a full pass of shifts returns the original word.

The separate shift and store clocks are modelled as single-cycle strobes on one system clock. An active-low select gates every clocked operation. An active-low clear empties the holding register at once, with or without the select.

Top module: `sl_shift_store_loop`

## Requirements
- R1: After a synchronous reset (rst high across a clock edge), both the shifter and the holding register read zero, so par_q = 0 and ser_out = 0.
- R2: With cs_n = 0, mode_rd = 0 (write) and shift_stb = 1, a clock edge moves shifter bit i into bit i+1 and loads ser_in into bit 0. After sixteen such shifts, the first bit shifted in sits in bit 15.
- R3: With cs_n = 0, mode_rd = 1 (read) and shift_stb = 1, a clock edge moves the old bit 15 into bit 0, and ser_in has no effect. Before the k-th read shift (k = 0..15), ser_out shows bit 15-k of the word, and sixteen read shifts restore the word.
- R4: ser_out always equals shifter bit 15.
- R5: With cs_n = 0 and store_stb = 1, the shifter contents appear on par_q after the clock edge.
- R6: With cs_n = 0 and reload = 1, the shifter takes the holding register value at the clock edge. When reload and shift_stb arrive in the same cycle, the reload wins.
- R7: clr_n = 0 forces par_q to zero at once, without a clock edge. While clr_n is low, a store strobe has no effect.
- R8: clr_n clears the holding register even while cs_n = 1.
- R9: While cs_n = 1, shift_stb, store_stb and reload have no effect on either register.
- R10: ser_oe is 1 only when cs_n = 0 and mode_rd = 1 (read). Otherwise it is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low select gating all clocked operations |
| clr_n | input | 1 | Active-low asynchronous clear of the holding register |
| mode_rd | input | 1 | Serial line direction: 1 = read (drive out), 0 = write (accept) |
| shift_stb | input | 1 | One-cycle shift strobe |
| store_stb | input | 1 | One-cycle strobe copying the shifter into the holding register |
| reload | input | 1 | Copy the holding register into the shifter |
| ser_in | input | 1 | Serial input bit of the shared line |
| ser_out | output | 1 | Serial output bit (shifter MSB) |
| ser_oe | output | 1 | Output enable of the shared line |
| par_q | output | WIDTH | Holding register contents |

## Verification
On every cycle, the assertions check the following:
- each shift, store and reload lands the right value one edge later;
- the select freezes the serial output and the holding register;
- the output enable never rises without the select;
- the holding register reads zero whenever clear is low.

Only the bench's scenarios can show the rest. The clear acts between clock edges, so it needs a scenario that looks between edges. A full read pass must return the original word. Reload must beat a shift in the same cycle. The clear must still work while the select is high.

// File: rtl/sl_pkg.sv
package sl_pkg;
  localparam int SL_WIDTH = 16;

  typedef enum logic {
    PORT_WRITE = 1'b0,
    PORT_READ  = 1'b1
  } port_mode_e;
endpackage

// File: rtl/sl_port_ctl.sv
module sl_port_ctl
  import sl_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       cs_n,
  input  port_mode_e mode,
  input  logic       shift_stb,
  input  logic       store_stb,
  input  logic       reload,
  input  logic       ser_in,
  input  logic       msb,
  output logic       shift_en,
  output logic       load_en,
  output logic       store_en,
  output logic       feed_bit,
  output logic       ser_oe
);
  logic sel;

  always_comb begin
    sel      = ~cs_n;
    load_en  = sel & reload;
    shift_en = sel & shift_stb & ~reload;
    store_en = sel & store_stb;
    feed_bit = (mode == PORT_READ) ? msb : ser_in;
    ser_oe   = sel & (mode == PORT_READ);
  end

  // R10: the line is never driven without the select
  a_r10_oe_needs_cs: assert property (@(posedge clk) disable iff (rst)
    ser_oe |-> !cs_n);

  // R6: a reload never coincides with a shift
  a_r6_reload_beats_shift: assert property (@(posedge clk) disable iff (rst)
    load_en |-> !shift_en);
endmodule

// File: rtl/sl_shifter.sv
module sl_shifter #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             shift_en,
  input  logic             load_en,
  input  logic             feed_bit,
  input  logic [WIDTH-1:0] par_in,
  output logic [WIDTH-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)
      q <= '0;
    else if (load_en)
      q <= par_in;
    else if (shift_en)
      q <= {q[WIDTH-2:0], feed_bit};
  end

  // R2, R3: shift step
  a_r2_shift_step: assert property (@(posedge clk) disable iff (rst)
    shift_en |=> q == {$past(q[WIDTH-2:0]), $past(feed_bit)});

  // R6: reload takes the parallel input
  a_r6_reload_value: assert property (@(posedge clk) disable iff (rst)
    load_en |=> q == $past(par_in));
endmodule

// File: rtl/sl_store.sv
module sl_store #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_n,
  input  logic             store_en,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n)
      q <= '0;
    else if (rst)
      q <= '0;
    else if (store_en)
      q <= d;
  end

  // R7, R8: clear holds the register at zero
  a_r7_clear_zero: assert property (@(posedge clk) disable iff (rst)
    !clr_n |-> q == '0);

  // R5: store captures the data
  a_r5_store_value: assert property (@(posedge clk) disable iff (rst)
    (store_en && clr_n) |=> (!clr_n || q == $past(d)));
endmodule

// File: rtl/sl_shift_store_loop.sv
module sl_shift_store_loop
  import sl_pkg::*;
#(
  parameter int WIDTH = SL_WIDTH
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cs_n,
  input  logic             clr_n,
  input  logic             mode_rd,
  input  logic             shift_stb,
  input  logic             store_stb,
  input  logic             reload,
  input  logic             ser_in,
  output logic             ser_out,
  output logic             ser_oe,
  output logic [WIDTH-1:0] par_q
);
  logic [WIDTH-1:0] shreg;
  logic             shift_en, load_en, store_en, feed_bit;

  sl_port_ctl u_ctl (
    .clk      (clk),
    .rst      (rst),
    .cs_n     (cs_n),
    .mode     (port_mode_e'(mode_rd)),
    .shift_stb(shift_stb),
    .store_stb(store_stb),
    .reload   (reload),
    .ser_in   (ser_in),
    .msb      (shreg[WIDTH-1]),
    .shift_en (shift_en),
    .load_en  (load_en),
    .store_en (store_en),
    .feed_bit (feed_bit),
    .ser_oe   (ser_oe)
  );

  sl_shifter #(.WIDTH(WIDTH)) u_shift (
    .clk     (clk),
    .rst     (rst),
    .shift_en(shift_en),
    .load_en (load_en),
    .feed_bit(feed_bit),
    .par_in  (par_q),
    .q       (shreg)
  );

  sl_store #(.WIDTH(WIDTH)) u_store (
    .clk     (clk),
    .rst     (rst),
    .clr_n   (clr_n),
    .store_en(store_en),
    .d       (shreg),
    .q       (par_q)
  );

  assign ser_out = shreg[WIDTH-1];

  // R9: select high freezes the serial side
  a_r9_cs_freezes_serial: assert property (@(posedge clk) disable iff (rst)
    cs_n |=> $stable(ser_out));

  // R9: select high freezes the holding register unless cleared
  a_r9_cs_freezes_store: assert property (@(posedge clk) disable iff (rst)
    (cs_n && clr_n) |=> (!clr_n || $stable(par_q)));

  // R3: read-mode shift recirculates the MSB into bit 0
  a_r3_recirculate: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && mode_rd && shift_stb && !reload) |=> shreg[0] == $past(ser_out));
endmodule

// File: tb/sl_shift_store_loop_tb.sv
module sl_shift_store_loop_tb;
  localparam int W = 16;
  localparam time CLK_PERIOD = 10;

  logic clk = 0, rst = 1, cs_n = 1, clr_n = 1, mode_rd = 0;
  logic shift_stb = 0, store_stb = 0, reload = 0, ser_in = 0;
  logic ser_out, ser_oe;
  logic [W-1:0] par_q;
  int checks = 0, errors = 0;

  sl_shift_store_loop #(.WIDTH(W)) u_dut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .clr_n(clr_n), .mode_rd(mode_rd),
    .shift_stb(shift_stb), .store_stb(store_stb), .reload(reload),
    .ser_in(ser_in), .ser_out(ser_out), .ser_oe(ser_oe), .par_q(par_q)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Strobe signals are driven at the falling edge and cleared after one cycle.
  task automatic cycle(input logic sh, input logic st, input logic rl, input logic si);
    shift_stb = sh; store_stb = st; reload = rl; ser_in = si;
    @(negedge clk);
    shift_stb = 0; store_stb = 0; reload = 0; ser_in = 0;
  endtask

  task automatic write_word(input logic [W-1:0] w);
    cs_n = 0; mode_rd = 0;
    for (int i = W-1; i >= 0; i--) cycle(1, 0, 0, w[i]);
  endtask

  task automatic t_reset();
    rst = 1;
    repeat (2) @(negedge clk);
    rst = 0;
    check("R1 par_q", par_q, 0);
    check("R1 ser_out", ser_out, 0);
  endtask

  task automatic t_write_store();
    write_word(16'hA5C3);
    check("R4 ser_out msb", ser_out, 1);
    cycle(0, 1, 0, 0);
    check("R2 R5 stored word", par_q, 16'hA5C3);
    write_word(16'h0001);
    check("R4 ser_out zero msb", ser_out, 0);
    cycle(0, 1, 0, 0);
    check("R2 R5 second word", par_q, 16'h0001);
  endtask

  task automatic t_read_recirc();
    logic [W-1:0] w = 16'h9E31;
    write_word(w);
    mode_rd = 1;
    for (int k = 0; k < W; k++) begin
      check($sformatf("R3 ser_out k=%0d", k), ser_out, w[W-1-k]);
      cycle(1, 0, 0, ~w[W-1-k]);
    end
    cycle(0, 1, 0, 0);
    check("R3 word restored", par_q, w);
    mode_rd = 0;
  endtask

  task automatic t_reload();
    write_word(16'h1234);
    cycle(0, 1, 0, 0);
    write_word(16'hFEDC);
    cycle(1, 0, 1, 1);
    check("R6 reload beats shift msb", ser_out, 0);
    cycle(0, 1, 0, 0);
    check("R6 reload value", par_q, 16'h1234);
  endtask

  task automatic t_clear();
    write_word(16'h7777);
    cycle(0, 1, 0, 0);
    check("R5 pre-clear", par_q, 16'h7777);
    clr_n = 0; store_stb = 1;
    #1;
    check("R7 async clear", par_q, 0);
    @(negedge clk);
    store_stb = 0;
    check("R7 clear beats store", par_q, 0);
    clr_n = 1;
    cycle(0, 1, 0, 0);
    check("R5 store after clear", par_q, 16'h7777);
    cs_n = 1;
    @(negedge clk);
    clr_n = 0;
    #1;
    check("R8 clear with cs high", par_q, 0);
    @(negedge clk);
    clr_n = 1;
    cs_n = 0;
  endtask

  task automatic t_cs_high();
    write_word(16'h3C5A);
    cycle(0, 1, 0, 0);
    write_word(16'h8421);
    cs_n = 1;
    cycle(1, 0, 0, 0);
    check("R9 shift ignored ser_out", ser_out, 1);
    cycle(0, 1, 0, 0);
    check("R9 store ignored", par_q, 16'h3C5A);
    cycle(0, 0, 1, 0);
    cs_n = 0;
    cycle(0, 1, 0, 0);
    check("R9 shifter untouched", par_q, 16'h8421);
  endtask

  task automatic t_oe();
    cs_n = 0; mode_rd = 1; #1;
    check("R10 oe read cs low", ser_oe, 1);
    mode_rd = 0; #1;
    check("R10 oe write cs low", ser_oe, 0);
    cs_n = 1; mode_rd = 1; #1;
    check("R10 oe read cs high", ser_oe, 0);
    mode_rd = 0; #1;
    check("R10 oe write cs high", ser_oe, 0);
    cs_n = 0;
    @(negedge clk);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_write_store();
    t_read_recirc();
    t_reload();
    t_clear();
    t_cs_high();
    t_oe();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule